// File: doc/BRIEF.md
# Addressable LED Waveform Encoder

This block turns a stream of 24-bit pixel words into the single-wire, pulse-width-coded line signal that drives a chain of addressable RGB LEDs. Each data bit goes out as a high pulse followed by a low pulse. The widths of those pulses, in clock cycles, are set separately for a zero bit and for a one bit. A run-time code chooses the order in which the red, green and blue bytes of a pixel leave the block. After the programmed number of pixels, the line is held low for a programmable latch gap, and then a one-cycle completion pulse is raised.

Pixel words arrive on a valid/ready stream. The encoder has one holding slot, so it can take the next word while the current one is still being shifted out. Back-pressure follows the usual rule: a word moves only in a cycle where `px_valid` and `px_ready` are both high. `px_ready` is low while the slot is full, while the block is idle, and once every word of the frame has been taken. The source must keep `px_data` stable while `px_valid` is high and `px_ready` is low. The source may withhold data in the middle of a frame: the line then stays low and the frame continues when the data arrives. Software converts nanosecond timings into cycle counts and programs the counts directly. All configuration inputs must stay stable while `busy` is high.

Top module: `pixel_line_encoder`

## Requirements
- R1: An input word carries red in bits 23:16, green in 15:8 and blue in 7:0. `order_sel` picks the order in which the bytes are sent: 0 = R,G,B; 1 = R,B,G; 2 = G,R,B; 3 = G,B,R; 4 = B,R,G; 5 = B,G,R. The codes 6 and 7 behave as code 2.
- R2: Within each byte, bits leave most-significant first. The three bytes of a pixel go out back to back.
- R3: A zero bit is high for exactly `t0_high` cycles and then low for exactly `t0_low` cycles. A one bit is high for exactly `t1_high` cycles and then low for `t1_low` cycles. A programmed count of 0 acts as 1.
- R4: A pulse on `go` while idle starts a frame of exactly `frame_len` pixels. A word is taken only when `px_valid && px_ready`. `px_ready` is high only while a frame is running, the holding slot is empty and words of the frame remain to be taken. When the source always has data, the next pixel starts right after the previous pixel's last low phase.
- R5: If no word is available when a pixel should start, the line stays low and `busy` stays high. Transmission resumes when a word arrives. The frame is not cut short.
- R6: After the low phase of the frame's last bit, the line stays low for `gap_len` more cycles (0 acts as 1). `done` is then high for exactly one cycle, and in the next cycle `busy` is low.
- R7: While idle, `led_out`, `px_ready`, `done` and `busy` are all low. A `go` pulse that arrives while a frame or its gap is in progress has no effect.
- R8: With `frame_len` equal to 0, a `go` pulse takes no words, produces no high pulse, and goes straight to the latch gap and the `done` pulse.
- R9: After reset the block is idle with every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Starts a frame when sampled high while idle |
| order_sel | input | 3 | Colour byte order code |
| t0_high | input | 5 | High-phase cycles of a zero bit |
| t0_low | input | 6 | Low-phase cycles of a zero bit |
| t1_high | input | 6 | High-phase cycles of a one bit |
| t1_low | input | 5 | Low-phase cycles of a one bit |
| frame_len | input | 13 | Pixels per frame |
| gap_len | input | 13 | Latch-gap cycles after the last bit |
| px_valid | input | 1 | Source has a pixel word |
| px_data | input | 24 | Pixel word, red high byte, blue low byte |
| px_ready | output | 1 | Encoder takes the word this cycle if valid |
| led_out | output | 1 | Serial line to the LED chain |
| busy | output | 1 | Frame or gap in progress |
| done | output | 1 | One-cycle pulse at the end of the latch gap |

## Verification
Every cycle, the assertions check these rules: the line and the stream stay quiet while idle; `done` is a single-cycle pulse with the line low, followed at once by idle; `px_ready` never rises outside a frame; and a frame only ever begins after a `go`. The values that show the function itself can only come from the bench's scenarios. These are the exact pulse widths, the bytes rebuilt from those widths in each of the eight order codes, the length of the latch gap, the starvation pause in mid-frame, and the zero-length frame.

// File: rtl/pxl_enc_pkg.sv
package pxl_enc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_DONE
  } enc_state_t;

  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_RBG = 3'd1;
  localparam logic [2:0] ORD_GRB = 3'd2;
  localparam logic [2:0] ORD_GBR = 3'd3;
  localparam logic [2:0] ORD_BRG = 3'd4;
  localparam logic [2:0] ORD_BGR = 3'd5;
endpackage

// File: rtl/pxl_color_order.sv
module pxl_color_order #(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]          order_sel,
  input  logic [3*BYTE_W-1:0] pix_in,
  output logic [3*BYTE_W-1:0] pix_out
);
  import pxl_enc_pkg::*;

  logic [BYTE_W-1:0] red, grn, blu;

  assign red = pix_in[3*BYTE_W-1:2*BYTE_W];
  assign grn = pix_in[2*BYTE_W-1:BYTE_W];
  assign blu = pix_in[BYTE_W-1:0];

  always_comb begin
    unique case (order_sel)
      ORD_RGB: pix_out = {red, grn, blu};
      ORD_RBG: pix_out = {red, blu, grn};
      ORD_GBR: pix_out = {grn, blu, red};
      ORD_BRG: pix_out = {blu, red, grn};
      ORD_BGR: pix_out = {blu, grn, red};
      default: pix_out = {grn, red, blu};
    endcase
  end
endmodule

// File: rtl/pxl_phase_counter.sv
module pxl_phase_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff_val;

  assign eff_val = (load_val == '0) ? W'(1) : load_val;
  assign last    = (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= eff_val;
    end else if (cnt > W'(1)) begin
      cnt <= cnt - W'(1);
    end
  end
endmodule

// File: rtl/pixel_line_encoder.sv
module pixel_line_encoder #(
  parameter int BYTE_W = 8,
  parameter int T0H_W  = 5,
  parameter int T0L_W  = 6,
  parameter int T1H_W  = 6,
  parameter int T1L_W  = 5,
  parameter int LEN_W  = 13,
  parameter int GAP_W  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [2:0]          order_sel,
  input  logic [T0H_W-1:0]    t0_high,
  input  logic [T0L_W-1:0]    t0_low,
  input  logic [T1H_W-1:0]    t1_high,
  input  logic [T1L_W-1:0]    t1_low,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic [GAP_W-1:0]    gap_len,
  input  logic                px_valid,
  input  logic [3*BYTE_W-1:0] px_data,
  output logic                px_ready,
  output logic                led_out,
  output logic                busy,
  output logic                done
);
  import pxl_enc_pkg::*;

  localparam int PIX_W = 3 * BYTE_W;
  localparam int BIT_W = $clog2(PIX_W);
  localparam int HI_W  = (T0H_W > T1H_W) ? T0H_W : T1H_W;
  localparam int LO_W  = (T0L_W > T1L_W) ? T0L_W : T1L_W;
  localparam int PH_W  = (HI_W > LO_W) ? HI_W : LO_W;

  enc_state_t       state;
  logic [PIX_W-1:0] shifter;
  logic [BIT_W-1:0] bit_idx;
  logic [PIX_W-1:0] hold_word;
  logic             hold_full;
  logic [LEN_W-1:0] fetch_left;
  logic [LEN_W-1:0] send_left;
  logic [PIX_W-1:0] ordered;

  logic             accept;
  logic             pix_end;
  logic             frame_end;
  logic             take_hold;
  logic             ph_load;
  logic [PH_W-1:0]  ph_val;
  logic             ph_last;
  logic             gap_load;
  logic             gap_last;

  pxl_color_order #(.BYTE_W(BYTE_W)) order_i (
    .order_sel (order_sel),
    .pix_in    (px_data),
    .pix_out   (ordered)
  );

  pxl_phase_counter #(.W(PH_W)) phase_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .last     (ph_last)
  );

  pxl_phase_counter #(.W(GAP_W)) gap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_len),
    .last     (gap_last)
  );

  function automatic logic [PH_W-1:0] high_of(input logic b);
    return b ? PH_W'(t1_high) : PH_W'(t0_high);
  endfunction

  function automatic logic [PH_W-1:0] low_of(input logic b);
    return b ? PH_W'(t1_low) : PH_W'(t0_low);
  endfunction

  assign px_ready  = (state != ST_IDLE) && (state != ST_DONE) &&
                     !hold_full && (fetch_left != '0);
  assign accept    = px_valid && px_ready;
  assign pix_end   = (bit_idx == '0);
  assign frame_end = (send_left == LEN_W'(1));
  assign take_hold = hold_full &&
                     ((state == ST_WAIT) ||
                      ((state == ST_LOW) && ph_last && pix_end && !frame_end));

  always_comb begin
    ph_load  = 1'b0;
    ph_val   = '0;
    gap_load = 1'b0;
    unique case (state)
      ST_IDLE: gap_load = go && (frame_len == '0);
      ST_WAIT: begin
        ph_load = hold_full;
        ph_val  = high_of(hold_word[PIX_W-1]);
      end
      ST_HIGH: begin
        ph_load = ph_last;
        ph_val  = low_of(shifter[PIX_W-1]);
      end
      ST_LOW: begin
        if (ph_last && !pix_end) begin
          ph_load = 1'b1;
          ph_val  = high_of(shifter[PIX_W-2]);
        end else if (ph_last && frame_end) begin
          gap_load = 1'b1;
        end else if (take_hold) begin
          ph_load = 1'b1;
          ph_val  = high_of(hold_word[PIX_W-1]);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word  <= '0;
      hold_full  <= 1'b0;
      fetch_left <= '0;
    end else if (state == ST_IDLE) begin
      hold_full  <= 1'b0;
      fetch_left <= go ? frame_len : '0;
    end else if (accept) begin
      hold_word  <= ordered;
      hold_full  <= 1'b1;
      fetch_left <= fetch_left - LEN_W'(1);
    end else if (take_hold) begin
      hold_full  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shifter   <= '0;
      bit_idx   <= '0;
      send_left <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          send_left <= frame_len;
          state     <= (frame_len == '0) ? ST_GAP : ST_WAIT;
        end
        ST_WAIT: if (hold_full) begin
          shifter <= hold_word;
          bit_idx <= BIT_W'(PIX_W - 1);
          state   <= ST_HIGH;
        end
        ST_HIGH: if (ph_last) state <= ST_LOW;
        ST_LOW: if (ph_last) begin
          if (!pix_end) begin
            shifter <= shifter << 1;
            bit_idx <= bit_idx - BIT_W'(1);
            state   <= ST_HIGH;
          end else begin
            send_left <= send_left - LEN_W'(1);
            if (frame_end) begin
              state <= ST_GAP;
            end else if (hold_full) begin
              shifter <= hold_word;
              bit_idx <= BIT_W'(PIX_W - 1);
              state   <= ST_HIGH;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_GAP:  if (gap_last) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign led_out = (state == ST_HIGH);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
endmodule

// File: rtl/pixel_line_encoder_chk.sv
module pixel_line_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic px_valid,
  input logic px_ready,
  input logic led_out,
  input logic busy,
  input logic done
);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!led_out && !px_ready && !done));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !led_out);

  assert_no_ready_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !px_ready);

  assert_start_needs_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  assert_ready_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready) |-> busy);
endmodule

bind pixel_line_encoder pixel_line_encoder_chk chk_i (.*);

// File: tb/pixel_line_encoder_tb_top.sv
module pixel_line_encoder_tb_top;
  // Counts derived from the nominal 336/840/882/294 ns bit timing and a
  // 300 us gap for a 42 ns module tick; the bench clock itself runs at 125 MHz.
  localparam int T0H = 8, T0L = 20, T1H = 21, T1L = 7, GAP_NOM = 7142;

  logic        clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [2:0]  order_sel = 3'd2;
  logic [4:0]  t0_high = 5'(T0H);
  logic [5:0]  t0_low  = 6'(T0L);
  logic [5:0]  t1_high = 6'(T1H);
  logic [4:0]  t1_low  = 5'(T1L);
  logic [12:0] frame_len = '0, gap_len = 13'd30;
  logic        px_valid = 1'b0;
  logic [23:0] px_data = '0;
  logic        px_ready, led_out, busy, done;

  always #4 clk = ~clk;

  pixel_line_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .order_sel(order_sel),
    .t0_high(t0_high), .t0_low(t0_low), .t1_high(t1_high), .t1_low(t1_low),
    .frame_len(frame_len), .gap_len(gap_len), .px_valid(px_valid),
    .px_data(px_data), .px_ready(px_ready), .led_out(led_out),
    .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;

  // Stream source
  logic [23:0] src_mem [0:15];
  int src_n = 0, src_idx = 0;
  bit adv = 0;
  always @(negedge clk) if (px_valid && px_ready) adv = 1;
  always begin
    @(posedge clk); #1;
    if (adv) begin src_idx++; adv = 0; end
    px_valid = (src_idx < src_n);
    px_data  = src_mem[src_idx % 16];
  end

  // Line monitor: width of every high pulse and of the low that follows it
  int hi_w [0:255];
  int lo_w [0:255];
  int nbits = 0, done_seen = 0, done_low = 0, run = 0;
  bit prev = 0;
  always @(negedge clk) begin
    if (done) begin done_seen++; done_low = run; end
    if (led_out) begin
      if (!prev) begin if (nbits > 0 && nbits <= 256) lo_w[nbits-1] = run; run = 1; end
      else run++;
    end else begin
      if (prev) begin if (nbits < 256) hi_w[nbits] = run; nbits++; run = 1; end
      else run++;
    end
    prev = led_out;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] exp_order(input logic [23:0] w, input int o);
    logic [7:0] r, g, b;
    r = w[23:16]; g = w[15:8]; b = w[7:0];
    case (o)
      0: return {r, g, b};
      1: return {r, b, g};
      3: return {g, b, r};
      4: return {b, r, g};
      5: return {b, g, r};
      default: return {g, r, b};
    endcase
  endfunction

  task automatic start_frame(input int ord, input int len, input int gap, input int avail);
    @(posedge clk); #1;
    order_sel = 3'(ord); frame_len = 13'(len); gap_len = 13'(gap);
    src_idx = 0; adv = 0; src_n = avail;
    nbits = 0; done_seen = 0; done_low = 0;
    go = 1'b1;
    @(posedge clk); #1;
    go = 1'b0;
  endtask

  task automatic wait_done(input int n);
    for (int i = 0; i < 60000 && done_seen < n; i++) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // Rebuilds pixels from pulse widths; checks widths and data (R1 R2 R3 R6)
  task automatic check_frame(input int npix, input int ord, input int skip_lo);
    int h0, h1, l0, l1, badw, badl, exp_l;
    logic [23:0] got, exp;
    h0 = eff(int'(t0_high)); h1 = eff(int'(t1_high));
    l0 = eff(int'(t0_low));  l1 = eff(int'(t1_low));
    chk(nbits == 24 * npix, "R4 bit count", nbits, 24 * npix);
    for (int p = 0; p < npix && nbits == 24 * npix; p++) begin
      exp = exp_order(src_mem[p], ord);
      got = '0; badw = 0; badl = 0;
      for (int k = 0; k < 24; k++) begin
        int i = 24 * p + k;
        got[23-k] = (hi_w[i] == h1);
        if (hi_w[i] != h1 && hi_w[i] != h0) badw++;
        if (hi_w[i] != (exp[23-k] ? h1 : h0)) badw++;
        if (i != 24 * npix - 1 && i != skip_lo && lo_w[i] != (exp[23-k] ? l1 : l0)) badl++;
      end
      chk(got == exp, "R1 R2 pixel bytes", got, exp);
      chk(badw == 0, "R3 high widths", badw, 0);
      chk(badl == 0, "R3 low widths", badl, 0);
    end
    exp_l = (src_mem[npix-1][0] || 1'b0) ? 0 : 0;
    exp_l = (exp_order(src_mem[npix-1], ord)[0] ? l1 : l0) + eff(int'(gap_len));
    chk(done_low == exp_l, "R6 last low plus gap", done_low, exp_l);
    chk(done_seen == 1, "R6 single done pulse", done_seen, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!led_out && !busy && !px_ready && !done, "R9 reset outputs idle",
        {led_out, busy, px_ready, done}, 0);
  endtask

  task automatic t_nominal;
    src_mem[0] = 24'hFF_00_81; src_mem[1] = 24'h12_34_56; src_mem[2] = 24'hA5_5A_C3;
    src_mem[3] = 24'hDE_AD_BE;
    start_frame(2, 3, GAP_NOM, 4);
    wait_done(1);
    check_frame(3, 2, -1);
    chk(src_idx == 3, "R4 words taken", src_idx, 3);
    @(negedge clk);
    chk(!busy, "R6 idle after done", busy, 0);
  endtask

  task automatic t_orders;
    src_mem[0] = 24'hC4_2B_96;
    for (int o = 0; o < 8; o++) begin
      start_frame(o, 1, 30, 1);
      wait_done(1);
      check_frame(1, o, -1);
    end
  endtask

  task automatic t_starve;
    src_mem[0] = 24'h0F_F0_3C; src_mem[1] = 24'h81_7E_01;
    start_frame(0, 2, 25, 1);
    repeat (1500) @(posedge clk);
    @(negedge clk);
    chk(busy && !led_out && done_seen == 0, "R5 stalled line low and busy",
        {busy, led_out, 1'(done_seen)}, 3'b100);
    chk(nbits == 24, "R5 first pixel sent before stall", nbits, 24);
    src_n = 2;
    wait_done(1);
    check_frame(2, 0, 23);
    chk(lo_w[23] > 500, "R5 stretched low during stall", lo_w[23], 501);
  endtask

  task automatic t_zero_len;
    src_mem[0] = 24'hFF_FF_FF;
    start_frame(2, 0, 40, 2);
    wait_done(1);
    chk(nbits == 0, "R8 no pulses", nbits, 0);
    chk(src_idx == 0, "R8 no words taken", src_idx, 0);
    chk(done_seen == 1, "R8 done raised", done_seen, 1);
  endtask

  task automatic t_go_busy;
    src_mem[0] = 24'h55_AA_0F; src_mem[1] = 24'h11_22_33; src_mem[2] = 24'h44_55_66;
    start_frame(2, 1, 30, 3);
    repeat (100) @(posedge clk);
    #1 go = 1'b1; @(posedge clk); #1 go = 1'b0;
    wait_done(1);
    repeat (200) @(posedge clk);
    @(negedge clk);
    chk(nbits == 24 && src_idx == 1, "R7 go while busy ignored", nbits, 24);
    chk(!busy && done_seen == 1, "R7 idle after single frame", {busy, 1'(done_seen)}, 1);
  endtask

  task automatic t_zero_count;
    t0_high = 5'd0;
    src_mem[0] = 24'h00_00_00;
    start_frame(0, 1, 0, 1);
    wait_done(1);
    check_frame(1, 0, -1);
    chk(hi_w[0] == 1, "R3 zero count acts as one", hi_w[0], 1);
    t0_high = 5'(T0H);
  endtask

  bit finished = 0;
  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_nominal();
    t_orders();
    t_starve();
    t_zero_len();
    t_go_busy();
    t_zero_count();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule